// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Combined-Error Flag Rules

The block receives asynchronous serial frames on a single line. A frame is a low start bit, then data bits with the least significant bit first, then an optional parity bit, then a stop bit. A 16x oversampling tick paces reception. Every bit is sampled once at its midpoint. The start bit is confirmed at its midpoint before the frame is accepted. Each frame is assembled in an internal shift register. At the end of the frame, the block decides whether the byte moves into the receive data register and which status flags it raises.

The transfer rule depends on which errors occur together. If the data register still holds an unread byte, the new frame is discarded and an overrun is flagged, whatever else went wrong in that frame. A frame with only framing and/or parity errors is still transferred, but the receive-full flag is not set. Error flags are sticky until a per-flag clear strobe arrives. A synchronized copy of the line level is brought out. Software can read it after a framing error: a line that is still low means a break, and reception continues through the break.

Top module: `uart_rx_errbuf`

## Requirements
- R1: After reset the receive data register reads 0 and the receive-full, overrun, framing and parity flags all read 0.
- R2: A frame with no framing error, no parity error and no overrun copies its byte into the receive data register and sets receive-full.
- R3: A low pulse on the line that is high again at the start bit's midpoint (8 ticks after detection) starts no frame: data and all flags are unchanged.
- R4: With parity enabled, even parity expects the parity bit to equal the XOR of the data bits, and odd parity expects its inverse. A mismatch sets the parity flag. With parity disabled, no parity bit is expected.
- R5: A frame that ends while receive-full is 1 sets the overrun flag, leaves the receive data register unchanged and leaves receive-full at 1.
- R6: A frame whose stop bit is sampled low sets the framing flag and still transfers its byte when no overrun occurs.
- R7: A frame that ends with a framing and/or parity error and no overrun transfers its byte and leaves receive-full at its previous value (0).
- R8: A frame with an overrun plus framing and parity errors sets all three error flags and does not transfer the byte.
- R9: A pulse on the read strobe clears receive-full, including after an overrun, and leaves the error flags unchanged.
- R10: Each error flag holds until its own clear strobe is pulsed. When a set event and a clear happen in the same cycle, the flag ends up set.
- R11: While the line is held low, frames keep completing. Each one sets the framing flag again after software clears it, and each transfers a zero byte.
- R12: The line-level output follows the serial input through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Raw serial input line |
| baud_tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Read of the receive data register; clears receive-full |
| clr_ovr | input | 1 | Clears the overrun flag |
| clr_frm | input | 1 | Clears the framing flag |
| clr_par | input | 1 | Clears the parity flag |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_frm | output | 1 | Framing-error flag |
| rx_par | output | 1 | Parity-error flag |
| rxd_level | output | 1 | Synchronized serial line level |

## Verification
The hardest situation to reach from the ports is a flag clear that lands in the same cycle as a frame end. The cycle of the frame end is internal and drifts with start-bit detection. The bench therefore holds the line low in a break and holds the framing clear high for longer than one frame. It then watches every cycle for the framing flag to appear. The flag can only be seen if the set beats the clear. The combined overrun cases are reached by leaving the data register unread across two frames while the second frame carries a bad parity bit and a low stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Frame engine phases
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // Error outcome of one completed frame
  typedef struct packed {
    logic ferr;
    logic perr;
  } rx_err_t;

  // Index of each sticky error flag in the flag bank
  localparam int FLG_OVR = 0;
  localparam int FLG_FRM = 1;
  localparam int FLG_PAR = 2;
  localparam int FLG_NUM = 3;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  // Line idles high, so the chain resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output rx_err_t           err
);

  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] shr_q, shr_d;
  logic              pbit_q, pbit_d;
  logic              done_q, done_d;
  rx_err_t           err_q, err_d;
  logic              exp_par;

  // Parity bit the frame should carry for the assembled data
  assign exp_par = (^shr_q) ^ par_odd;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shr_d   = shr_q;
    pbit_d  = pbit_q;
    done_d  = 1'b0;
    err_d   = err_q;
    if (tick) begin
      case (state_q)
        RX_IDLE: begin
          if (!rx) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = rx ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
            shr_d = {rx, shr_q[DATA_W-1:1]};
            if (bit_q == LAST_BIT) begin
              state_d = par_en ? RX_PAR : RX_STOP;
            end else begin
              bit_d = bit_q + BW'(1);
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            pbit_d  = rx;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d      = '0;
            state_d    = RX_IDLE;
            done_d     = 1'b1;
            err_d.ferr = ~rx;
            err_d.perr = par_en & (pbit_q != exp_par);
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          state_d = RX_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shr_q   <= '0;
      pbit_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shr_q   <= shr_d;
      pbit_q  <= pbit_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign done = done_q;
  assign data = shr_q;
  assign err  = err_q;

endmodule

// File: rtl/rx_flag_ctl.sv
module rx_flag_ctl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] fdata,
  input  rx_err_t           err,
  input  logic              rd,
  input  logic              clr_ovr,
  input  logic              clr_frm,
  input  logic              clr_par,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic [FLG_NUM-1:0] flags
);

  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               full_q, full_d;
  logic               xfer;
  logic               clean;
  logic [FLG_NUM-1:0] set_v;
  logic [FLG_NUM-1:0] clr_v;

  // An unread register blocks the move; errors alone do not
  assign xfer  = done & ~full_q;
  assign clean = ~err.ferr & ~err.perr;

  assign set_v[FLG_OVR] = done & full_q;
  assign set_v[FLG_FRM] = done & err.ferr;
  assign set_v[FLG_PAR] = done & err.perr;
  assign clr_v[FLG_OVR] = clr_ovr;
  assign clr_v[FLG_FRM] = clr_frm;
  assign clr_v[FLG_PAR] = clr_par;

  always_comb begin
    rdata_d = xfer ? fdata : rdata_q;
    if (xfer && clean) begin
      full_d = 1'b1;
    end else if (rd) begin
      full_d = 1'b0;
    end else begin
      full_d = full_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      full_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      full_q  <= full_d;
    end
  end

  // One sticky slice per error flag; set has priority over clear
  for (genvar g = 0; g < FLG_NUM; g++) begin : g_flag
    logic flg_q, flg_d;
    always_comb begin
      flg_d = set_v[g] | (flg_q & ~clr_v[g]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q <= 1'b0;
      end else begin
        flg_q <= flg_d;
      end
    end
    assign flags[g] = flg_q;
  end

  assign rdata = rdata_q;
  assign full  = full_q;

endmodule

// File: rtl/uart_rx_errbuf.sv
module uart_rx_errbuf
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_in,
  input  logic              baud_tick16,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_strobe,
  input  logic              clr_ovr,
  input  logic              clr_frm,
  input  logic              clr_par,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              rx_frm,
  output logic              rx_par,
  output logic              rxd_level
);

  logic               rx_s;
  logic               frm_done;
  logic [DATA_W-1:0]  frm_data;
  rx_err_t            frm_err;
  logic [FLG_NUM-1:0] flg;

  rx_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd_in),
    .dout (rx_s)
  );

  rx_frame_engine #(
    .DATA_W(DATA_W),
    .OSR   (OSR)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (baud_tick16),
    .rx     (rx_s),
    .par_en (par_en),
    .par_odd(par_odd),
    .done   (frm_done),
    .data   (frm_data),
    .err    (frm_err)
  );

  rx_flag_ctl #(
    .DATA_W(DATA_W)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (frm_done),
    .fdata  (frm_data),
    .err    (frm_err),
    .rd     (rd_strobe),
    .clr_ovr(clr_ovr),
    .clr_frm(clr_frm),
    .clr_par(clr_par),
    .rdata  (rx_data),
    .full   (rx_full),
    .flags  (flg)
  );

  assign rx_ovr    = flg[FLG_OVR];
  assign rx_frm    = flg[FLG_FRM];
  assign rx_par    = flg[FLG_PAR];
  assign rxd_level = rx_s;

endmodule

// File: rtl/uart_rx_errbuf_chk.sv
module uart_rx_errbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [DATA_W-1:0] fdata,
  input logic              ferr,
  input logic              perr,
  input logic              rd,
  input logic              clr_frm,
  input logic              full,
  input logic              ovr,
  input logic              frm,
  input logic [DATA_W-1:0] rdata
);

  // R2
  clean_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full && !ferr && !perr) |=> (full && rdata == $past(fdata)));

  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full) |=> (ovr && rdata == $past(rdata)));

  // R7
  err_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full && (ferr || perr)) |=> (!full && rdata == $past(fdata)));

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> !full);

  // R6
  frm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ferr) |=> frm);

  // R10
  frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm && !clr_frm) |=> frm);

endmodule

bind uart_rx_errbuf uart_rx_errbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .done   (frm_done),
  .fdata  (frm_data),
  .ferr   (frm_err.ferr),
  .perr   (frm_err.perr),
  .rd     (rd_strobe),
  .clr_frm(clr_frm),
  .full   (rx_full),
  .ovr    (rx_ovr),
  .frm    (rx_frm),
  .rdata  (rx_data)
);

// File: tb/sim_uart_rx_errbuf.sv
`timescale 1ns/1ps
module sim_uart_rx_errbuf;

  localparam int BIT_CYC = 32;  // 16 ticks, one tick every 2 cycles
  localparam int NVEC    = 11;
  localparam int WD_MAX  = 150000;

  typedef struct packed {
    logic [7:0] dat;
    logic       pen;
    logic       podd;
    logic       badp;
    logic       stop;
    logic       rd_pre;
    logic       clr_pre;
    logic       e_full;
    logic       e_ovr;
    logic       e_frm;
    logic       e_par;
    logic [7:0] e_dat;
  } vec_t;

  // dat pen podd badp stop rd clr | full ovr frm par e_dat
  localparam logic [25:0] VECS [NVEC] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5}, // R2
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C}, // R2 R4 even
    {8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C}, // R5
    {8'h5A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A}, // R9 R4 odd
    {8'h0F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0F}, // R4 R7
    {8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77}, // R6
    {8'hC3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3}, // R7
    {8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11}, // R2
    {8'h22, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h11}, // R8
    {8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h44}, // R9 R10
    {8'h99, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h99}  // R4 R10
  };

  logic       clk;
  logic       rst_n;
  logic       rxd_in;
  logic       baud_tick16;
  logic       par_en;
  logic       par_odd;
  logic       rd_strobe;
  logic       clr_ovr;
  logic       clr_frm;
  logic       clr_par;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       rx_ovr;
  logic       rx_frm;
  logic       rx_par;
  logic       rxd_level;

  int checks;
  int errors;
  int cyc;
  bit done_flag;

  uart_rx_errbuf u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd_in     (rxd_in),
    .baud_tick16(baud_tick16),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .rd_strobe  (rd_strobe),
    .clr_ovr    (clr_ovr),
    .clr_frm    (clr_frm),
    .clr_par    (clr_par),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .rx_ovr     (rx_ovr),
    .rx_frm     (rx_frm),
    .rx_par     (rx_par),
    .rxd_level  (rxd_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) baud_tick16 <= 1'b0;
    else        baud_tick16 <= ~baud_tick16;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_MAX && !done_flag) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, WD_MAX);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1;
    wait_cyc(1);
    rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr_all();
    clr_ovr = 1'b1; clr_frm = 1'b1; clr_par = 1'b1;
    wait_cyc(1);
    clr_ovr = 1'b0; clr_frm = 1'b0; clr_par = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pen,
                            input logic podd, input logic badp,
                            input logic stop);
    par_en  = pen;
    par_odd = podd;
    rxd_in  = 1'b0;
    wait_cyc(BIT_CYC);
    for (int i = 0; i < 8; i++) begin
      rxd_in = d[i];
      wait_cyc(BIT_CYC);
    end
    if (pen) begin
      rxd_in = (^d) ^ podd ^ badp;
      wait_cyc(BIT_CYC);
    end
    rxd_in = stop;
    wait_cyc(BIT_CYC);
    rxd_in = 1'b1;
    wait_cyc(2 * BIT_CYC);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; done_flag = 1'b0;
    rst_n = 1'b0; rxd_in = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    rd_strobe = 1'b0; clr_ovr = 1'b0; clr_frm = 1'b0; clr_par = 1'b0;
    wait_cyc(3);
    // R1 reset state
    chk("R1", "data", 32'(rx_data), 32'h00);
    chk("R1", "full", 32'(rx_full), 32'h0);
    chk("R1", "flags", {29'd0, rx_ovr, rx_frm, rx_par}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R12", "idle level", 32'(rxd_level), 32'h1);

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      v = vec_t'(VECS[k]);
      if (v.rd_pre)  pulse_rd();
      if (v.clr_pre) pulse_clr_all();
      send_frame(v.dat, v.pen, v.podd, v.badp, v.stop);
      chk("R2", $sformatf("vec%0d data", k), 32'(rx_data), 32'(v.e_dat));
      chk("R7", $sformatf("vec%0d full", k), 32'(rx_full), 32'(v.e_full));
      chk("R5", $sformatf("vec%0d ovr", k), 32'(rx_ovr), 32'(v.e_ovr));
      chk("R6", $sformatf("vec%0d frm", k), 32'(rx_frm), 32'(v.e_frm));
      chk("R4", $sformatf("vec%0d par", k), 32'(rx_par), 32'(v.e_par));
    end

    // R9: read clears full, error flags unchanged
    pulse_rd();
    wait_cyc(1);
    chk("R9", "full after read", 32'(rx_full), 32'h0);
    chk("R9", "par kept", 32'(rx_par), 32'h1);

    // R3: short low glitch starts no frame
    pulse_clr_all();
    rxd_in = 1'b0;
    wait_cyc(8);
    rxd_in = 1'b1;
    wait_cyc(16 * BIT_CYC);
    chk("R3", "data", 32'(rx_data), 32'h99);
    chk("R3", "full", 32'(rx_full), 32'h0);
    chk("R3", "flags", {29'd0, rx_ovr, rx_frm, rx_par}, 32'h0);

    // R11: break handling
    par_en = 1'b0;
    rxd_in = 1'b0;
    wait_cyc(12 * BIT_CYC);
    chk("R11", "frm in break", 32'(rx_frm), 32'h1);
    chk("R11", "zero byte", 32'(rx_data), 32'h00);
    chk("R11", "full in break", 32'(rx_full), 32'h0);
    chk("R12", "low level", 32'(rxd_level), 32'h0);
    clr_frm = 1'b1;
    wait_cyc(1);
    clr_frm = 1'b0;
    chk("R10", "frm cleared", 32'(rx_frm), 32'h0);
    wait_cyc(12 * BIT_CYC);
    chk("R11", "frm set again", 32'(rx_frm), 32'h1);
    // R10: clear held across a frame end; set must win once
    begin
      bit seen;
      seen = 1'b0;
      clr_frm = 1'b1;
      wait_cyc(1);
      for (int i = 0; i < 13 * BIT_CYC; i++) begin
        if (rx_frm) seen = 1'b1;
        wait_cyc(1);
      end
      clr_frm = 1'b0;
      chk("R10", "set beats clear", 32'(seen), 32'h1);
    end
    rxd_in = 1'b1;
    wait_cyc(3);
    chk("R12", "high level", 32'(rxd_level), 32'h1);
    wait_cyc(3 * BIT_CYC);

    // R1: reset in the middle of activity
    pulse_rd();
    pulse_clr_all();
    send_frame(8'h6E, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'h6F, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5", "ovr before reset", 32'(rx_ovr), 32'h1);
    chk("R5", "data kept", 32'(rx_data), 32'h6E);
    rst_n = 1'b0;
    wait_cyc(2);
    chk("R1", "data after reset", 32'(rx_data), 32'h00);
    chk("R1", "full after reset", 32'(rx_full), 32'h0);
    chk("R1", "ovr after reset", 32'(rx_ovr), 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);

    done_flag = 1'b1;
    summary();
    $finish;
  end

endmodule